// File: doc/BRIEF.md
# DDR3 Write-Aware Termination Controller

This block sits on the memory-controller side of a DDR3 interface and decides, cycle by cycle, the level of the on-die termination enable pin and which termination value the DRAM holds: none, the nominal value, or the write value. It watches the command stream the controller issues. Mode-register writes set two enable bits, one for nominal termination and one for write termination. Write commands open a write-termination window that starts CAS write latency cycles later. The block moves between the nominal and write values on its own around each write burst, so no mode-register write is needed for the switch.

A DLL-disable input forces termination off, because the DRAM cannot terminate in that mode. A mode-register write that tries to turn termination on while the DLL is disabled raises an error pulse. A second error pulse flags writes issued closer together than the eight-beat spacing. Burst-chop writes count as eight-beat writes for this spacing, but they hold the write window open for only half as long. A status code tells the rest of the controller which termination is in effect.

Top module: `odt_term_ctrl`

## Requirements
- R1: While reset is asserted and until the first command after its release, `odt` is 0, `odt_state` is 0 (off), and both error outputs are 0.
- R2: A command with `cmd_op` = 3 (mode write) loads the nominal enable from `cmd_data[0]` and the write enable from `cmd_data[1]`. From the next cycle, with only the nominal enable set, `odt` is 1 and `odt_state` is 1 (nominal).
- R3: A command with `cmd_op` = 1 (write) and `cmd_chop` = 0, sampled at clock edge k, opens a write window after edges k+CWL through k+CWL+3 (4 cycles). `cwl` gives CWL, which is held steady while writes are in flight.
- R4: With both enables set, `odt_state` is 1 outside a write window and 2 (write) inside it, and it returns to 1 after the window. `odt` stays 1 throughout.
- R5: With only the write enable set, `odt` is 1 and `odt_state` is 2 inside a write window. At all other times both are 0.
- R6: A write with `cmd_chop` = 1 opens a window of 2 cycles instead of 4.
- R7: A write whose window starts while another window is open extends the open window. The window stays open without a gap until the later of the two window ends.
- R8: A write sampled fewer than 4 edges after the previous write sets `wr_gap_err` to 1 for the one cycle after it is sampled, whether or not either write is chopped. At all other times `wr_gap_err` is 0.
- R9: While `dll_off` is 1, `odt` is 0 and `odt_state` is 0, whatever the enables and windows.
- R10: A mode write with either data bit set, sampled while `dll_off` is 1, sets `dll_odt_err` to 1 for the next cycle. At all other times `dll_odt_err` is 0.
- R11: Read commands (`cmd_op` = 2) and no-ops (`cmd_op` = 0) leave `odt`, `odt_state` and both error outputs unchanged.
- R12: Any CWL from 1 to 8 gives the window timing of R3, under mixed random commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_op | input | 2 | Command: 0 no-op, 1 write, 2 read, 3 mode write |
| cmd_chop | input | 1 | Write is burst-chop (half-length window) |
| cmd_data | input | 2 | Mode write enables: bit 0 nominal, bit 1 write |
| cwl | input | 4 | CAS write latency in clocks |
| dll_off | input | 1 | DLL-disable mode active |
| odt | output | 1 | Termination enable pin level |
| odt_state | output | 2 | Termination in effect: 0 off, 1 nominal, 2 write |
| wr_gap_err | output | 1 | Write-to-write spacing violation pulse |
| dll_odt_err | output | 1 | Termination enable attempted in DLL-disable mode |

## Verification
A wrong latency tap or a broken delay line moves the start of the write window. This shows on `odt_state` at edge k+CWL, no more than nine cycles after the write. A bad window counter or a bad extension rule shortens, stretches or splits the window, and the fault appears within four cycles of the window opening. Stale or swapped enable bits show on `odt` and `odt_state` in the cycle after the mode write. The reference model marks every window cycle independently, so each of these faults produces a mismatch on the first affected cycle.

// File: rtl/odt_term_pkg.sv
package odt_term_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_MODE  = 2'd3
  } odt_op_e;

  typedef enum logic [1:0] {
    TERM_OFF = 2'd0,
    TERM_NOM = 2'd1,
    TERM_WR  = 2'd2
  } term_state_e;

  // window lengths in clocks and the minimum write spacing
  localparam int unsigned BL8_CLKS = 4;
  localparam int unsigned BC4_CLKS = 2;

endpackage

// File: rtl/odt_wr_window.sv
module odt_wr_window
  import odt_term_pkg::*;
#(
  parameter int unsigned CWL_MAX = 8,
  parameter int unsigned CWL_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic             wr_chop,
  input  logic [CWL_W-1:0] cwl,
  output logic             win_open
);
  localparam int unsigned SEL_W = (CWL_MAX > 1) ? $clog2(CWL_MAX) : 1;
  localparam int unsigned LEN_W = $clog2(BL8_CLKS + 1);

  logic [CWL_MAX-1:0] vld_q, vld_d, chop_q, chop_d;
  logic               pipe_en;
  logic [SEL_W-1:0]   sel;
  logic               tap, tap_chop;
  logic [LEN_W-1:0]   cnt_q, cnt_d, dec, len;
  logic               cnt_en;

  // latency tap select, clamped to the implemented range
  always_comb begin
    if (cwl == '0)
      sel = '0;
    else if (cwl > CWL_W'(CWL_MAX))
      sel = SEL_W'(CWL_MAX - 1);
    else
      sel = SEL_W'(cwl - CWL_W'(1));
  end

  assign tap      = vld_q[sel];
  assign tap_chop = chop_q[sel];

  // delay line: each write carries its own chop flag
  always_comb begin
    vld_d   = {vld_q[CWL_MAX-2:0], wr_fire};
    chop_d  = {chop_q[CWL_MAX-2:0], wr_chop & wr_fire};
    pipe_en = wr_fire | (|vld_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      chop_q <= '0;
    end else if (pipe_en) begin
      vld_q  <= vld_d;
      chop_q <= chop_d;
    end
  end

  // window counter: a new start keeps the longer of remaining and new length
  always_comb begin
    dec    = (cnt_q == '0) ? '0 : cnt_q - LEN_W'(1);
    len    = tap_chop ? LEN_W'(BC4_CLKS) : LEN_W'(BL8_CLKS);
    cnt_d  = dec;
    if (tap && (len > dec))
      cnt_d = len;
    cnt_en = tap | (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign win_open = (cnt_q != '0);

endmodule

// File: rtl/odt_gap_check.sv
module odt_gap_check
  import odt_term_pkg::*;
#(
  parameter int unsigned SPACING = BL8_CLKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  output logic gap_err
);
  localparam int unsigned CNT_W = $clog2(SPACING + 1);

  logic [CNT_W-1:0] since_q, since_d;
  logic             err_d, since_en;

  always_comb begin
    since_en = wr_fire | (since_q != CNT_W'(SPACING));
    err_d    = wr_fire & (since_q < CNT_W'(SPACING));
    if (wr_fire)
      since_d = CNT_W'(1);
    else
      since_d = since_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= CNT_W'(SPACING);
      gap_err <= 1'b0;
    end else begin
      gap_err <= err_d;
      if (since_en)
        since_q <= since_d;
    end
  end

endmodule

// File: rtl/odt_term_ctrl.sv
module odt_term_ctrl
  import odt_term_pkg::*;
#(
  parameter int unsigned CWL_MAX = 8,
  parameter int unsigned CWL_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_chop,
  input  logic [1:0]       cmd_data,
  input  logic [CWL_W-1:0] cwl,
  input  logic             dll_off,
  output logic             odt,
  output logic [1:0]       odt_state,
  output logic             wr_gap_err,
  output logic             dll_odt_err
);
  logic [1:0]  rst_pipe_q;
  logic        rst_i_n;
  odt_op_e     op;
  logic        wr_fire, mode_fire;
  logic        nom_en_q, nom_en_d, wr_en_q, wr_en_d, mode_en;
  logic        derr_d;
  logic        win_open;
  term_state_e state;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= 2'b00;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  assign op        = odt_op_e'(cmd_op);
  assign wr_fire   = (op == OP_WRITE);
  assign mode_fire = (op == OP_MODE);

  // enable bits loaded by mode writes
  always_comb begin
    mode_en  = mode_fire;
    nom_en_d = cmd_data[0];
    wr_en_d  = cmd_data[1];
    derr_d   = mode_fire & dll_off & (|cmd_data);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      nom_en_q    <= 1'b0;
      wr_en_q     <= 1'b0;
      dll_odt_err <= 1'b0;
    end else begin
      dll_odt_err <= derr_d;
      if (mode_en) begin
        nom_en_q <= nom_en_d;
        wr_en_q  <= wr_en_d;
      end
    end
  end

  odt_wr_window #(
    .CWL_MAX (CWL_MAX),
    .CWL_W   (CWL_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_fire  (wr_fire),
    .wr_chop  (cmd_chop),
    .cwl      (cwl),
    .win_open (win_open)
  );

  odt_gap_check #(
    .SPACING (BL8_CLKS)
  ) u_gap (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_fire (wr_fire),
    .gap_err (wr_gap_err)
  );

  // termination selection; DLL-disable overrides everything
  always_comb begin
    if (dll_off) begin
      state = TERM_OFF;
      odt   = 1'b0;
    end else if (wr_en_q && win_open) begin
      state = TERM_WR;
      odt   = 1'b1;
    end else if (nom_en_q) begin
      state = TERM_NOM;
      odt   = 1'b1;
    end else begin
      state = TERM_OFF;
      odt   = 1'b0;
    end
  end

  assign odt_state = state;

endmodule

// File: rtl/odt_term_chk.sv
module odt_term_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd_op,
  input logic [1:0] cmd_data,
  input logic       dll_off,
  input logic       odt,
  input logic [1:0] odt_state,
  input logic       wr_gap_err,
  input logic       dll_odt_err
);
  logic wr_now, bad_mode;
  assign wr_now   = (cmd_op == 2'd1);
  assign bad_mode = (cmd_op == 2'd3) && dll_off && (cmd_data != 2'b00);

  AST_DLL_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dll_off |-> (!odt && odt_state == 2'd0)); // R9

  AST_DLL_ENABLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |=> dll_odt_err); // R10

  AST_DLL_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dll_odt_err |-> $past(bad_mode)); // R10

  AST_B2B_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && $past(wr_now)) |=> wr_gap_err); // R8

  AST_WRITE_TERM_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_state == 2'd2) |-> odt); // R4

  AST_OFF_MEANS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_state == 2'd0) |-> !odt); // R5

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    odt_state != 2'd3); // R2

endmodule

bind odt_term_ctrl odt_term_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_op      (cmd_op),
  .cmd_data    (cmd_data),
  .dll_off     (dll_off),
  .odt         (odt),
  .odt_state   (odt_state),
  .wr_gap_err  (wr_gap_err),
  .dll_odt_err (dll_odt_err)
);

// File: tb/tb_odt_term_ctrl.sv
module tb_odt_term_ctrl;
  logic       clk;
  logic       rst_n;
  logic [1:0] cmd_op;
  logic       cmd_chop;
  logic [1:0] cmd_data;
  logic [3:0] cwl;
  logic       dll_off;
  logic       odt;
  logic [1:0] odt_state;
  logic       wr_gap_err;
  logic       dll_odt_err;

  odt_term_ctrl dut (
    .clk (clk), .rst_n (rst_n), .cmd_op (cmd_op), .cmd_chop (cmd_chop),
    .cmd_data (cmd_data), .cwl (cwl), .dll_off (dll_off), .odt (odt),
    .odt_state (odt_state), .wr_gap_err (wr_gap_err), .dll_odt_err (dll_odt_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  int    last_wr = -1000;
  string cur_tag = "R1";
  bit    open_m [0:1023];
  bit    m_nom, m_wr, exp_gap, exp_derr;
  bit    finished = 0;

  task automatic chk(input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", cur_tag, what, cyc, act, exp);
    end
  endtask

  function automatic int exp_state(input bit win, input bit dll);
    if (dll) return 0;
    if (m_wr && win) return 2;
    if (m_nom) return 1;
    return 0;
  endfunction

  // reference model, updated on the edge, compared shortly after it
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) open_m[i] = 0;
      m_nom = 0; m_wr = 0; exp_gap = 0; exp_derr = 0; last_wr = -1000;
    end else begin
      open_m[(cyc + 1023) & 1023] = 0;
      exp_gap = 0; exp_derr = 0;
      if (cmd_op == 2'd1) begin
        for (int i = 0; i < (cmd_chop ? 2 : 4); i++)
          open_m[(cyc + int'(cwl) + i) & 1023] = 1;
        exp_gap = (cyc - last_wr) < 4;
        last_wr = cyc;
      end else if (cmd_op == 2'd3) begin
        exp_derr = dll_off && (cmd_data != 2'b00);
        m_nom = cmd_data[0];
        m_wr  = cmd_data[1];
      end
    end
    #1;
    if (!finished) begin
      chk("odt_state", int'(odt_state), exp_state(open_m[cyc & 1023], dll_off));
      chk("odt", int'(odt), (exp_state(open_m[cyc & 1023], dll_off) != 0) ? 1 : 0);
      chk("wr_gap_err", int'(wr_gap_err), int'(exp_gap));
      chk("dll_odt_err", int'(dll_odt_err), int'(exp_derr));
    end
  end

  task automatic step(input logic [1:0] op, input logic chop, input logic [1:0] data);
    @(negedge clk);
    cmd_op = op; cmd_chop = chop; cmd_data = data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'd0, 1'b0, 2'b00);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1977));
    rst_n = 1'b0; cmd_op = 2'd0; cmd_chop = 1'b0; cmd_data = 2'b00;
    cwl = 4'd5; dll_off = 1'b0;
    cur_tag = "R1";
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    idle(5);

    cur_tag = "R2";   step(2'd3, 0, 2'b01); idle(6);
    cur_tag = "R11";  step(2'd2, 0, 2'b11); step(2'd2, 1, 2'b10); idle(1); step(2'd2, 0, 2'b00); idle(5);
    cur_tag = "R5";   step(2'd3, 0, 2'b10); idle(2); step(2'd1, 0, 2'b00); idle(14);
    cur_tag = "R3";   cwl = 4'd8; idle(2); step(2'd1, 0, 2'b00); idle(16); cwl = 4'd1; idle(1);
                      step(2'd1, 0, 2'b00); idle(10); cwl = 4'd5;
    cur_tag = "R4";   step(2'd3, 0, 2'b11); idle(2); step(2'd1, 0, 2'b00); idle(12);
    cur_tag = "R6";   step(2'd1, 1, 2'b00); idle(12);
    cur_tag = "R7";   step(2'd1, 0, 2'b00); idle(3); step(2'd1, 1, 2'b00); idle(1);
                      step(2'd1, 0, 2'b00); idle(3); step(2'd1, 1, 2'b00); idle(14);
    cur_tag = "R8";   step(2'd1, 0, 2'b00); step(2'd1, 1, 2'b00); idle(2); step(2'd1, 0, 2'b00); idle(14);
    cur_tag = "R9";   dll_off = 1'b1; step(2'd1, 0, 2'b00); idle(12);
    cur_tag = "R10";  step(2'd3, 0, 2'b01); idle(2); step(2'd3, 0, 2'b00); idle(2); step(2'd3, 0, 2'b11); idle(3);
                      dll_off = 1'b0; idle(4);

    cur_tag = "R12";
    for (int blk = 0; blk < 30; blk++) begin
      idle(16);
      cwl = 4'(1 + ($urandom % 8));
      for (int i = 0; i < 100; i++) begin
        int r;
        r = $urandom % 10;
        if (($urandom % 40) == 0) dll_off = ~dll_off;
        if (r < 3)       step(2'd1, 1'($urandom % 2), 2'b00);
        else if (r < 4)  step(2'd3, 1'b0, 2'($urandom % 4));
        else if (r < 6)  step(2'd2, 1'($urandom % 2), 2'($urandom % 4));
        else             step(2'd0, 1'b0, 2'b00);
      end
    end
    dll_off = 1'b0;
    idle(16);
    finish_run();
  end
endmodule